// File: doc/BRIEF.md
# Multicycle Processor Datapath with Unified Memory

This block is the datapath half of a 32-bit processor that runs each instruction over several short cycles. A single ALU and a single memory are shared between those cycles. The ALU advances the program counter, forms branch targets, computes load and store addresses and does register arithmetic. The memory supplies both instruction words and data words. Values that one cycle produces and a later cycle consumes are kept in internal holding registers: the instruction register, the memory data register, two operand latches and the ALU result latch.

The block has no sequencing of its own. An external controller drives a bundle of control strobes every cycle. Each strobe steers a multiplexer or enables a write. The controller reads back the opcode and function fields of the held instruction, together with the ALU zero flag, to choose its next step. Typical sequences are: fetch, then decode, then an execute step, then an optional memory step, then an optional register write-back. The memory is a small internal word array. It is filled by the simulation environment before reset is released.

Top module: `mc_datapath`

## Requirements
- R1: While `rst_n` is low, the PC, instruction register, memory data register, both operand latches, the ALU result latch and all 32 registers clear to zero. Memory contents are not affected by reset.
- R2: The memory address is the PC when `addr_from_alu`=0 and the ALU result latch when it is 1. With `ir_wr`=1 the instruction register loads the addressed word at the clock edge; with `ir_wr`=0 it holds. `opcode` shows instruction bits [31:26] and `funct` shows bits [5:0].
- R3: With `pc_wr`=1 the PC loads, at the clock edge, the live ALU result when `pc_from_reg`=0 and the ALU result latch when `pc_from_reg`=1. With no load condition the PC holds.
- R4: With `pc_wr_cond`=1 and `pc_wr`=0 the PC loads the selected source only when `zero` is 1 in that cycle.
- R5: On every clock edge, the memory data register captures the addressed memory word. The first operand latch captures register[IR[25:21]], the second captures register[IR[20:16]], and the ALU result latch captures the ALU result.
- R6: `alu_fn` selects the operation: 0 add, 1 subtract (first minus second), 2 AND, 3 OR, 4 signed set-less-than (result 1 or 0). Codes 5 to 7 add. `zero` is 1 exactly when the ALU result is 0.
- R7: The first ALU operand is the PC when `opa_reg`=0 and the first operand latch when it is 1. `opb_sel` selects the second operand: 0 the second operand latch, 1 the constant 4, 2 IR[15:0] sign-extended, 3 that sign-extended value shifted left by two.
- R8: With `rf_wr`=1 a register is written at the clock edge. The destination is IR[20:16] when `rf_dst_rd`=0 and IR[15:11] when it is 1. The data is the ALU result latch when `rf_from_mdr`=0 and the memory data register when it is 1.
- R9: Register 0 always reads as zero. A write addressed to it has no effect.
- R10: With `mem_wr`=1 the second operand latch is written, at the clock edge, to the word at the selected address. A read of that word in a later cycle returns it.
- R11: The memory holds 256 words. It is indexed by address bits [9:2]; all other address bits are ignored, so addresses that differ only outside [9:2] reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_wr | input | 1 | Unconditional PC load |
| pc_wr_cond | input | 1 | PC load qualified by the zero flag |
| pc_from_reg | input | 1 | PC source: 0 live ALU result, 1 ALU result latch |
| addr_from_alu | input | 1 | Memory address: 0 PC, 1 ALU result latch |
| mem_wr | input | 1 | Memory write of the second operand latch |
| ir_wr | input | 1 | Instruction register load |
| rf_wr | input | 1 | Register file write |
| rf_dst_rd | input | 1 | Destination field: 0 IR[20:16], 1 IR[15:11] |
| rf_from_mdr | input | 1 | Write data: 0 ALU result latch, 1 memory data register |
| opa_reg | input | 1 | First ALU operand: 0 PC, 1 first operand latch |
| opb_sel | input | 2 | Second ALU operand select |
| alu_fn | input | 3 | ALU operation code |
| opcode | output | 6 | Instruction register bits [31:26] |
| funct | output | 6 | Instruction register bits [5:0] |
| zero | output | 1 | ALU result equals zero |

## Verification
Register and memory contents are not visible at the ports, so they are hardest to observe. The stimulus brings stored words back out with an unusual strobe sequence. An execute step computes an address into the result latch. The next cycle then loads the instruction register from that address, and the word appears on `opcode` and `funct`. The same path checks that a store made from register 0 writes zero. It also checks that a load through an address with bit 10 set reaches the same word as its aliased address. Register values become visible through `zero` during subtract and branch steps, which the behavioural model compares on every cycle.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int WORD_W = 32;
  localparam int IMM_W  = 16;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    FN_ADD = 3'd0,
    FN_SUB = 3'd1,
    FN_AND = 3'd2,
    FN_OR  = 3'd3,
    FN_SLT = 3'd4
  } alu_fn_e;

  typedef enum logic [1:0] {
    OPB_REG    = 2'd0,
    OPB_FOUR   = 2'd1,
    OPB_IMM    = 2'd2,
    OPB_IMM_X4 = 2'd3
  } opb_sel_e;

  // widen a 16-bit immediate, replicating its top bit
  function automatic word_t sext_imm(input logic [IMM_W-1:0] imm);
    return {{(WORD_W-IMM_W){imm[IMM_W-1]}}, imm};
  endfunction

  // arithmetic of the shared ALU; unlisted codes fall back to add
  function automatic word_t alu_eval(input logic [2:0] fn, input word_t a, input word_t b);
    word_t r;
    case (alu_fn_e'(fn))
      FN_SUB:  r = a - b;
      FN_AND:  r = a & b;
      FN_OR:   r = a | b;
      FN_SLT:  r = {{(WORD_W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: r = a + b;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
(
  input  logic [2:0] fn,
  input  word_t      opa,
  input  word_t      opb,
  output word_t      result,
  output logic       is_zero
);
  assign result  = alu_eval(fn, opa, opb);
  assign is_zero = (result == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
  import mc_pkg::*;
#(
  parameter int REG_COUNT = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [$clog2(REG_COUNT)-1:0] rsel_a,
  input  logic [$clog2(REG_COUNT)-1:0] rsel_b,
  output word_t                        rdata_a,
  output word_t                        rdata_b,
  input  logic                         wen,
  input  logic [$clog2(REG_COUNT)-1:0] wsel,
  input  word_t                        wdata
);
  localparam int SEL_W = $clog2(REG_COUNT);

  word_t regs_q [REG_COUNT];
  logic  write_hit;

  // register 0 is never a legal destination
  assign write_hit = wen && (wsel != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_COUNT; i++) regs_q[i] <= '0;
    end else if (write_hit) begin
      regs_q[wsel] <= wdata;
    end
  end

  assign rdata_a = regs_q[rsel_a];
  assign rdata_b = regs_q[rsel_b];

  assert_reg0_stays_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && wsel == '0) |=> (regs_q[0] == '0));

  assert_reg_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && wsel != '0) |=> (regs_q[$past(wsel)] == $past(wdata)));

  logic [SEL_W-1:0] unused_sel_copy;
  assign unused_sel_copy = wsel;
endmodule

// File: rtl/mc_memory.sv
module mc_memory
  import mc_pkg::*;
#(
  parameter int MEM_WORDS = 256
) (
  input  logic  clk,
  input  word_t addr,
  input  logic  wen,
  input  word_t wdata,
  output word_t rdata
);
  localparam int IDX_W = $clog2(MEM_WORDS);

  word_t             mem_q [MEM_WORDS];
  logic [IDX_W-1:0]  word_idx;

  // byte address to word index; bits outside the index are dropped
  assign word_idx = addr[IDX_W+1:2];

  always @(posedge clk) begin
    if (wen) mem_q[word_idx] <= wdata;
  end

  assign rdata = mem_q[word_idx];

  logic unused_addr_bits;
  assign unused_addr_bits = ^{addr[WORD_W-1:IDX_W+2], addr[1:0]};
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
#(
  parameter int MEM_WORDS = 256,
  parameter int REG_COUNT = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pc_wr,
  input  logic       pc_wr_cond,
  input  logic       pc_from_reg,
  input  logic       addr_from_alu,
  input  logic       mem_wr,
  input  logic       ir_wr,
  input  logic       rf_wr,
  input  logic       rf_dst_rd,
  input  logic       rf_from_mdr,
  input  logic       opa_reg,
  input  logic [1:0] opb_sel,
  input  logic [2:0] alu_fn,
  output logic [5:0] opcode,
  output logic [5:0] funct,
  output logic       zero
);
  localparam int SEL_W = $clog2(REG_COUNT);
  localparam word_t PC_STEP = word_t'(4);

  // holding registers between steps
  word_t pc_q, ir_q, mdr_q, opa_q, opb_q, alu_q;

  // named internal events
  word_t mem_addr, mem_rdata;
  word_t rf_a, rf_b, rf_wdata;
  word_t imm_ext, imm_x4;
  word_t alu_in_a, alu_in_b, alu_y;
  word_t pc_next;
  logic  alu_zero;
  logic  pc_load;
  logic [SEL_W-1:0] src1_sel, src2_sel, dst_sel;

  // instruction fields
  assign src1_sel = ir_q[25:21];
  assign src2_sel = ir_q[20:16];
  assign dst_sel  = rf_dst_rd ? ir_q[15:11] : ir_q[20:16];
  assign imm_ext  = sext_imm(ir_q[15:0]);
  assign imm_x4   = imm_ext << 2;

  // shared memory port
  assign mem_addr = addr_from_alu ? alu_q : pc_q;

  mc_memory #(.MEM_WORDS(MEM_WORDS)) u_mem (
    .clk   (clk),
    .addr  (mem_addr),
    .wen   (mem_wr),
    .wdata (opb_q),
    .rdata (mem_rdata)
  );

  // register file
  assign rf_wdata = rf_from_mdr ? mdr_q : alu_q;

  mc_regfile #(.REG_COUNT(REG_COUNT)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .rsel_a  (src1_sel),
    .rsel_b  (src2_sel),
    .rdata_a (rf_a),
    .rdata_b (rf_b),
    .wen     (rf_wr),
    .wsel    (dst_sel),
    .wdata   (rf_wdata)
  );

  // shared ALU and its operand steering
  assign alu_in_a = opa_reg ? opa_q : pc_q;

  always_comb begin
    case (opb_sel_e'(opb_sel))
      OPB_REG:    alu_in_b = opb_q;
      OPB_FOUR:   alu_in_b = PC_STEP;
      OPB_IMM:    alu_in_b = imm_ext;
      default:    alu_in_b = imm_x4;
    endcase
  end

  mc_alu u_alu (
    .fn      (alu_fn),
    .opa     (alu_in_a),
    .opb     (alu_in_b),
    .result  (alu_y),
    .is_zero (alu_zero)
  );

  // program counter
  assign pc_load = pc_wr | (pc_wr_cond & alu_zero);
  assign pc_next = pc_from_reg ? alu_q : alu_y;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ir_q  <= '0;
      mdr_q <= '0;
      opa_q <= '0;
      opb_q <= '0;
      alu_q <= '0;
    end else begin
      if (pc_load) pc_q <= pc_next;
      if (ir_wr)   ir_q <= mem_rdata;
      mdr_q <= mem_rdata;
      opa_q <= rf_a;
      opb_q <= rf_b;
      alu_q <= alu_y;
    end
  end

  assign opcode = ir_q[31:26];
  assign funct  = ir_q[5:0];
  assign zero   = alu_zero;

  logic unused_shamt;
  assign unused_shamt = ^ir_q[10:6];

  assert_pc_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_load |=> $stable(pc_q));

  assert_branch_takes_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr_cond && !pc_wr && zero && pc_from_reg) |=> (pc_q == $past(alu_q)));

  assert_ir_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_wr |=> $stable(ir_q));

  assert_zero_means_latch_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    zero |=> (alu_q == '0));

  assert_store_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (u_mem.wdata == opb_q));
endmodule

// File: tb/mc_datapath_bench.sv
module mc_datapath_bench;
  localparam int CLK_NS = 8;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       pc_from_reg;
    logic       addr_from_alu;
    logic       mem_wr;
    logic       ir_wr;
    logic       rf_wr;
    logic       rf_dst_rd;
    logic       rf_from_mdr;
    logic       opa_reg;
    logic [1:0] opb;
    logic [2:0] fn;
  } ctl_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  ctl_t ctl = '0;
  logic [5:0] opcode, funct;
  logic zero;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  mc_datapath u_mc_datapath (
    .clk           (clk),
    .rst_n         (rst_n),
    .pc_wr         (ctl.pc_wr),
    .pc_wr_cond    (ctl.pc_wr_cond),
    .pc_from_reg   (ctl.pc_from_reg),
    .addr_from_alu (ctl.addr_from_alu),
    .mem_wr        (ctl.mem_wr),
    .ir_wr         (ctl.ir_wr),
    .rf_wr         (ctl.rf_wr),
    .rf_dst_rd     (ctl.rf_dst_rd),
    .rf_from_mdr   (ctl.rf_from_mdr),
    .opa_reg       (ctl.opa_reg),
    .opb_sel       (ctl.opb),
    .alu_fn        (ctl.fn),
    .opcode        (opcode),
    .funct         (funct),
    .zero          (zero)
  );

  // behavioural reference state
  logic [31:0] m_pc, m_ir, m_mdr, m_a, m_b, m_alu;
  logic [31:0] m_rf [32];
  logic [31:0] m_mem [256];

  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fc);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fc[5:0]};
  endfunction

  function automatic logic [31:0] ref_op_b(ctl_t c);
    int imm;
    imm = int'($signed(m_ir[15:0]));
    if (c.opb == 2'd0) return m_b;
    if (c.opb == 2'd1) return 32'd4;
    if (c.opb == 2'd2) return 32'(imm);
    return 32'(imm * 4);
  endfunction

  function automatic logic [31:0] ref_result(ctl_t c);
    logic [31:0] x, y;
    int sx, sy;
    x = c.opa_reg ? m_a : m_pc;
    y = ref_op_b(c);
    sx = int'(x);
    sy = int'(y);
    if (c.fn == 3'd1) return x - y;
    if (c.fn == 3'd2) return x & y;
    if (c.fn == 3'd3) return x | y;
    if (c.fn == 3'd4) return (sx < sy) ? 32'd1 : 32'd0;
    return x + y;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge(ctl_t c);
    logic [31:0] y, addr, rd_word, n_pc, n_a, n_b;
    logic [4:0] dst;
    y = ref_result(c);
    addr = c.addr_from_alu ? m_alu : m_pc;
    rd_word = m_mem[addr[9:2]];
    n_pc = m_pc;
    if (c.pc_wr || (c.pc_wr_cond && y == 0)) n_pc = c.pc_from_reg ? m_alu : y;
    n_a = (m_ir[25:21] == 0) ? 32'd0 : m_rf[m_ir[25:21]];
    n_b = (m_ir[20:16] == 0) ? 32'd0 : m_rf[m_ir[20:16]];
    dst = c.rf_dst_rd ? m_ir[15:11] : m_ir[20:16];
    if (c.rf_wr && dst != 0) m_rf[dst] = c.rf_from_mdr ? m_mdr : m_alu;
    if (c.mem_wr) m_mem[addr[9:2]] = m_b;
    if (c.ir_wr) m_ir = rd_word;
    m_pc = n_pc;
    m_mdr = rd_word;
    m_a = n_a;
    m_b = n_b;
    m_alu = y;
  endtask

  // apply strobes at a falling edge, compare, then advance one clock
  task automatic step(ctl_t c, string tag);
    logic [31:0] y;
    ctl = c;
    #1;
    y = ref_result(c);
    check({tag, " zero"}, {31'd0, zero}, {31'd0, (y == 0)});
    check({tag, " opcode"}, {26'd0, opcode}, {26'd0, m_ir[31:26]});
    check({tag, " funct"}, {26'd0, funct}, {26'd0, m_ir[5:0]});
    @(posedge clk);
    model_edge(c);
    @(negedge clk);
  endtask

  task automatic do_fetch();
    ctl_t c = '0;
    c.ir_wr = 1'b1; c.pc_wr = 1'b1; c.opb = 2'd1; c.fn = 3'd0;
    step(c, "R2 R7 fetch");
  endtask

  task automatic do_decode();
    ctl_t c = '0;
    c.opb = 2'd3; c.fn = 3'd0;
    step(c, "R5 R7 decode");
  endtask

  task automatic do_addr_calc();
    ctl_t c = '0;
    c.opa_reg = 1'b1; c.opb = 2'd2; c.fn = 3'd0;
    step(c, "R7 address");
  endtask

  task automatic do_load();
    ctl_t c = '0;
    do_fetch(); do_decode(); do_addr_calc();
    c.addr_from_alu = 1'b1;
    step(c, "R5 load read");
    c = '0; c.rf_wr = 1'b1; c.rf_from_mdr = 1'b1;
    step(c, "R8 load writeback");
  endtask

  task automatic do_store();
    ctl_t c = '0;
    do_fetch(); do_decode(); do_addr_calc();
    c.addr_from_alu = 1'b1; c.mem_wr = 1'b1;
    step(c, "R10 store");
  endtask

  task automatic do_rtype(logic [2:0] fn);
    ctl_t c = '0;
    do_fetch(); do_decode();
    c.opa_reg = 1'b1; c.opb = 2'd0; c.fn = fn;
    step(c, "R6 execute");
    c = '0; c.rf_wr = 1'b1; c.rf_dst_rd = 1'b1;
    step(c, "R8 rtype writeback");
  endtask

  task automatic do_branch();
    ctl_t c = '0;
    do_fetch(); do_decode();
    c.opa_reg = 1'b1; c.fn = 3'd1; c.pc_wr_cond = 1'b1; c.pc_from_reg = 1'b1;
    step(c, "R4 branch compare");
  endtask

  // brings a memory word into the instruction register for observation
  task automatic do_peek(string tag, logic [5:0] exp_op, logic [5:0] exp_fc);
    ctl_t c = '0;
    do_fetch(); do_decode(); do_addr_calc();
    c.ir_wr = 1'b1; c.addr_from_alu = 1'b1;
    step(c, {tag, " peek"});
    check({tag, " peek opcode"}, {26'd0, opcode}, {26'd0, exp_op});
    check({tag, " peek funct"}, {26'd0, funct}, {26'd0, exp_fc});
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) m_mem[i] = '0;
    m_mem[0]  = enc_i(6'h23, 0, 2, 16'h0080);
    m_mem[1]  = enc_i(6'h23, 0, 3, 16'h0084);
    m_mem[2]  = enc_r(2, 3, 5, 6'h20);
    m_mem[3]  = enc_i(6'h2b, 0, 5, 16'h0088);
    m_mem[4]  = enc_r(3, 2, 6, 6'h22);
    m_mem[5]  = enc_r(6, 2, 7, 6'h2a);
    m_mem[6]  = enc_r(2, 3, 8, 6'h24);
    m_mem[7]  = enc_r(2, 3, 9, 6'h25);
    m_mem[8]  = enc_i(6'h04, 2, 3, 16'h0004);
    m_mem[9]  = enc_i(6'h04, 7, 8, 16'h0002);
    m_mem[10] = enc_r(2, 3, 11, 6'h20);
    m_mem[11] = enc_r(2, 3, 11, 6'h20);
    m_mem[12] = enc_r(2, 3, 0, 6'h20);
    m_mem[13] = enc_i(6'h2b, 0, 0, 16'h008c);
    m_mem[14] = enc_i(6'h23, 0, 10, 16'h0488);
    m_mem[15] = enc_i(6'h2b, 0, 10, 16'h0090);
    m_mem[16] = enc_i(6'h23, 0, 0, 16'h0088);
    m_mem[17] = enc_i(6'h23, 0, 0, 16'h008c);
    m_mem[18] = enc_i(6'h23, 0, 0, 16'h0090);
    m_mem[19] = enc_i(6'h04, 0, 0, 16'hffec);
    m_mem[32] = 32'h1000_0005;
    m_mem[33] = 32'h0800_0003;
    for (int i = 0; i < 256; i++) u_mc_datapath.u_mem.mem_q[i] = m_mem[i];
    for (int i = 0; i < 32; i++) m_rf[i] = '0;
    m_pc = '0; m_ir = '0; m_mdr = '0; m_a = '0; m_b = '0; m_alu = '0;

    repeat (3) @(negedge clk);
    // R1: state after reset: IR clear, PC + latch B is zero
    check("R1 reset opcode", {26'd0, opcode}, 32'd0);
    check("R1 reset funct", {26'd0, funct}, 32'd0);
    check("R1 reset zero", {31'd0, zero}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    do_load();            // r2
    do_load();            // r3
    do_rtype(3'd0);       // r5 = sum
    do_store();           // word 34
    do_rtype(3'd1);       // r6 = r3 - r2
    do_rtype(3'd4);       // r7 = slt
    do_rtype(3'd2);       // r8 = and
    do_rtype(3'd3);       // r9 = or
    do_branch();          // not taken
    do_fetch();
    check("R4 untaken branch falls through", {26'd0, opcode}, 32'h04);
    do_decode();
    begin
      ctl_t c = '0;
      c.opa_reg = 1'b1; c.fn = 3'd1; c.pc_wr_cond = 1'b1; c.pc_from_reg = 1'b1;
      step(c, "R4 branch taken");
    end
    do_fetch();
    check("R4 taken branch target opcode", {26'd0, opcode}, 32'h00);
    check("R4 taken branch target funct", {26'd0, funct}, 32'h20);
    do_decode();
    begin
      ctl_t c = '0;
      c.opa_reg = 1'b1; c.fn = 3'd0;
      step(c, "R6 execute r0 dest");
      c = '0; c.rf_wr = 1'b1; c.rf_dst_rd = 1'b1;
      step(c, "R9 write to register 0");
    end
    do_store();           // store r0 to word 35
    do_load();            // alias load into r10
    do_store();           // r10 to word 36
    do_peek("R10 stored sum", 6'h06, 6'h08);
    do_peek("R9 register 0 store", 6'h00, 6'h00);
    do_peek("R11 aliased load", 6'h06, 6'h08);
    do_fetch();
    do_decode();
    begin
      ctl_t c = '0;
      c.pc_wr = 1'b1; c.pc_from_reg = 1'b1;
      step(c, "R3 jump from latch");
    end
    do_fetch();
    check("R3 jump lands on word 0", {26'd0, opcode}, 32'h23);
    begin
      ctl_t c = '0;
      c.opb = 2'd1; c.fn = 3'd7;
      step(c, "R3 R6 hold without load");
    end
    do_decode();
    check("R3 PC held after fetch of word 0", {26'd0, opcode}, 32'h23);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_NS * 50000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL R1 watchdog actual=running expected=done");
      summary();
      $finish;
    end
  end
endmodule